// File: doc/BRIEF.md
# UTF-8 Step Decoder

This unit acts as a register-to-register instruction that turns the head of a UTF-8 string into one Unicode scalar value. Software loads the next four bytes of the string into a 32-bit operand. The earliest byte sits in the lowest byte lane. The unit returns a single 32-bit result word. That word carries the code point, the number of bytes the sequence used, and an error flag. The caller can advance its string pointer by the count field without needing a second destination register.

The first byte alone sets the sequence length. The unit then checks the continuation bytes and the decoded value. Any malformed input yields the replacement character with a length of one, so a caller that keeps stepping always makes forward progress. A valid strobe goes with each operand. The result is registered and appears one clock later with its own valid strobe. Bytes past the sequence length have no effect on the result.

Top module: `utf8_step_decoder`

## Requirements
- R1: A lead byte with bit 7 clear decodes as length 1, with the code point equal to that byte.
- R2: A lead byte of the form 110xxxxx with one continuation byte (10xxxxxx) in lane 1 decodes as length 2, with code point = lead[4:0] followed by cont[5:0].
- R3: A lead byte of the form 1110xxxx with continuation bytes in lanes 1 and 2 decodes as length 3, with code point = lead[3:0], lane1[5:0], lane2[5:0].
- R4: A lead byte of the form 11110xxx with continuation bytes in lanes 1 to 3 decodes as length 4, with code point = lead[2:0], lane1[5:0], lane2[5:0], lane3[5:0].
- R5: The result word places the code point in bits [20:0] and the byte count in bits [30:28]. Bits [27:21] are zero, and bit 31 is the error flag (1 = malformed).
- R6: If any byte that the length requires to be a continuation byte does not match 10xxxxxx, the result is the error word 0x9000FFFD (flag 1, length 1, code point 0xFFFD).
- R7: A lead byte of the form 10xxxxxx or 11111xxx gives the error word 0x9000FFFD.
- R8: An overlong form gives the error word. This covers a 2-byte value below 0x80, a 3-byte value below 0x800, and a 4-byte value below 0x10000.
- R9: A 3-byte sequence that decodes into 0xD800..0xDFFF gives the error word.
- R10: A 4-byte sequence that decodes above 0x10FFFF gives the error word.
- R11: Input lanes beyond the decoded length do not affect the result.
- R12: out_valid is high exactly in the cycle after a cycle with in_valid high. out_word then holds the result for the operand presented in that earlier cycle.
- R13: While in_valid is low, out_word keeps its last value.
- R14: Reset (rst_n low) clears out_valid and out_word to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand present this cycle |
| in_bytes | input | 32 | Next four string bytes, earliest in [7:0] |
| out_valid | output | 1 | Result present this cycle |
| out_word | output | 32 | {error, length[2:0], 7'b0, code point[20:0]} |

## Verification
The assertions check properties of every result word on every cycle:
- reserved bits are zero;
- the length field lies between 1 and 4;
- an error word has exactly the fixed replacement pattern;
- a clean result is never a surrogate, never above 0x10FFFF, and never overlong for its length;
- the valid strobe lags by one cycle, and the output holds when idle.

Only the bench's vectors show the rest:
- that each encoding produces the right code point;
- that each kind of malformation is caught rather than passed through;
- that trailing lanes are ignored.

// File: rtl/utf8_step_decoder.sv
module utf8_step_decoder (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] in_bytes,
  output logic        out_valid,
  output logic [31:0] out_word
);
  localparam logic [31:0] BAD_WORD = {1'b1, 3'd1, 7'd0, 21'h00FFFD};

  logic [7:0] b0, b1, b2, b3;
  assign {b3, b2, b1, b0} = in_bytes;

  logic c1, c2, c3;
  assign c1 = (b1[7:6] == 2'b10);
  assign c2 = (b2[7:6] == 2'b10);
  assign c3 = (b3[7:6] == 2'b10);

  logic [2:0]  len;
  logic        lead_ok;
  logic [20:0] cp;
  logic        bad;

  always_comb begin
    lead_ok = 1'b1;
    casez (b0)
      8'b0???????: len = 3'd1;
      8'b110?????: len = 3'd2;
      8'b1110????: len = 3'd3;
      8'b11110???: len = 3'd4;
      default: begin
        len = 3'd1;
        lead_ok = 1'b0;
      end
    endcase
  end

  always_comb begin
    case (len)
      3'd2:    cp = {10'd0, b0[4:0], b1[5:0]};
      3'd3:    cp = {5'd0, b0[3:0], b1[5:0], b2[5:0]};
      3'd4:    cp = {b0[2:0], b1[5:0], b2[5:0], b3[5:0]};
      default: cp = {14'd0, b0[6:0]};
    endcase
  end

  always_comb begin
    bad = !lead_ok;
    case (len)
      3'd2: bad = bad | !c1 | (cp < 21'h80);
      3'd3: bad = bad | !c1 | !c2 | (cp < 21'h800) |
                  ((cp >= 21'hD800) && (cp <= 21'hDFFF));
      3'd4: bad = bad | !c1 | !c2 | !c3 | (cp < 21'h10000) |
                  (cp > 21'h10FFFF);
      default: ;
    endcase
  end

  logic [31:0] result;
  assign result = bad ? BAD_WORD : {1'b0, len, 7'd0, cp};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= 32'd0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= result;
    end
  end
endmodule

module utf8_step_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] in_bytes,
  input logic        out_valid,
  input logic [31:0] out_word
);
  logic        err;
  logic [2:0]  n;
  logic [20:0] v;
  assign err = out_word[31];
  assign n   = out_word[30:28];
  assign v   = out_word[20:0];

  a_r12_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> out_valid == $past(in_valid));

  a_r13_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> $stable(out_word));

  a_r5_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_word[27:21] == 7'd0);

  a_r5_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (n >= 3'd1 && n <= 3'd4));

  a_r6_error_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && err) |-> out_word[30:0] == {3'd1, 7'd0, 21'h00FFFD});

  a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !err) |-> v <= 21'h10FFFF);

  a_r9_no_surrogate: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !err) |-> !(v >= 21'hD800 && v <= 21'hDFFF));

  a_r8_shortest_form: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !err) |->
      ((n == 3'd1 && v < 21'h80) ||
       (n == 3'd2 && v >= 21'h80 && v < 21'h800) ||
       (n == 3'd3 && v >= 21'h800 && v < 21'h10000) ||
       (n == 3'd4 && v >= 21'h10000)));

  a_r1_ascii_pass: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(in_valid) && !$past(in_bytes[7])) |->
      out_word == {1'b0, 3'd1, 7'd0, 14'd0, $past(in_bytes[6:0])});
endmodule

bind utf8_step_decoder utf8_step_decoder_chk i_chk (.*);

// File: tb/test_utf8_step_decoder.sv
module test_utf8_step_decoder;
  localparam time PERIOD = 10ns;
  localparam int  NV = 30;
  localparam logic [31:0] E = 32'h9000FFFD;

  // {requirement number[3:0], operand[31:0], expected word[31:0]}
  localparam logic [67:0] VEC [0:NV-1] = '{
    {4'd1,  32'hFFFFFF41, 32'h10000041},  // R1 'A', R11 junk lanes
    {4'd1,  32'h0000007F, 32'h1000007F},  // R1
    {4'd1,  32'h00000000, 32'h10000000},  // R1 NUL
    {4'd2,  32'h0000A9C3, 32'h200000E9},  // R2
    {4'd2,  32'h0000BFDF, 32'h200007FF},  // R2 max
    {4'd2,  32'h000080C2, 32'h20000080},  // R2 min
    {4'd3,  32'h00AC82E2, 32'h300020AC},  // R3
    {4'd3,  32'h00BFBFEF, 32'h3000FFFF},  // R3 max
    {4'd3,  32'h0080A0E0, 32'h30000800},  // R3 min
    {4'd3,  32'h008080EE, 32'h3000E000},  // R3 after surrogates
    {4'd3,  32'h00BF9FED, 32'h3000D7FF},  // R3 before surrogates
    {4'd4,  32'h80989FF0, 32'h4001F600},  // R4
    {4'd4,  32'hBFBF8FF4, 32'h4010FFFF},  // R4 max
    {4'd4,  32'h808090F0, 32'h40010000},  // R4 min
    {4'd11, 32'hFF80A9C3, 32'h200000E9},  // R11 junk after 2-byte
    {4'd6,  32'h000041C3, E},             // R6
    {4'd6,  32'h80289FF0, E},             // R6 third byte
    {4'd6,  32'h00C082E2, E},             // R6 lane2 is 11xxxxxx
    {4'd7,  32'h00000080, E},             // R7 stray continuation
    {4'd7,  32'h808080F8, E},             // R7 F8
    {4'd7,  32'hFFFFFFFF, E},             // R7 FF
    {4'd8,  32'h000080C0, E},             // R8 C0 80
    {4'd8,  32'h0000BFC1, E},             // R8 C1 BF
    {4'd8,  32'h00BF9FE0, E},             // R8 3-byte 0x7FF
    {4'd8,  32'hBFBF8FF0, E},             // R8 4-byte 0xFFFF
    {4'd9,  32'h0080A0ED, E},             // R9 D800
    {4'd9,  32'h00BFBFED, E},             // R9 DFFF
    {4'd10, 32'h808090F4, E},             // R10 110000
    {4'd10, 32'h808080F5, E},             // R10 F5 lead
    {4'd11, 32'h12345641, 32'h10000041}   // R11 other junk
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_bytes = 32'd0;
  logic        out_valid;
  logic [31:0] out_word;
  int          checks = 0;
  int          fails = 0;

  always #(PERIOD/2) clk = ~clk;

  utf8_step_decoder i_utf8_step_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bytes(in_bytes),
    .out_valid(out_valid), .out_word(out_word)
  );

  function automatic string rname(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";   10: return "R10"; 11: return "R11"; 12: return "R12";
      13: return "R13"; 14: return "R14"; default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input logic v, input logic [31:0] w,
                       input logic ev, input logic [31:0] ew);
    checks++;
    if (v !== ev || w !== ew) begin
      fails++;
      $display("FAIL %s: valid=%0b word=%08h expected valid=%0b word=%08h",
               req, v, w, ev, ew);
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: valid=%0b word=%08h expected run end", out_valid, out_word);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R14", out_valid, out_word, 1'b0, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", out_valid, out_word, 1'b0, 32'd0);

    // table, back to back (R12 latency one)
    for (int i = 0; i < NV; i++) begin
      in_valid = 1'b1;
      in_bytes = VEC[i][63:32];
      @(negedge clk);
      check(rname(int'(VEC[i][67:64])), out_valid, out_word, 1'b1, VEC[i][31:0]);
      check("R5", 1'b0, out_word[27:21] == 7'd0 ? 32'd0 : 32'd1, 1'b0, 32'd0);
    end

    // R13: idle with changing operand keeps the last word
    in_valid = 1'b0;
    in_bytes = 32'h0000A9C3;
    @(negedge clk);
    check("R13", out_valid, out_word, 1'b0, 32'h10000041);
    in_bytes = 32'hFFFFFFFF;
    @(negedge clk);
    check("R13", out_valid, out_word, 1'b0, 32'h10000041);

    // R12: single pulse, valid for one cycle only
    in_valid = 1'b1;
    in_bytes = 32'h00AC82E2;
    @(negedge clk);
    in_valid = 1'b0;
    check("R12", out_valid, out_word, 1'b1, 32'h300020AC);
    @(negedge clk);
    check("R12", out_valid, out_word, 1'b0, 32'h300020AC);

    // R14: reset mid-run clears state
    in_valid = 1'b1;
    in_bytes = 32'h80989FF0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R14", out_valid, out_word, 1'b0, 32'd0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R14", out_valid, out_word, 1'b0, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule